// File: doc/BRIEF.md
# Squared-Voltage Cycle Accumulator

This block builds, for each line cycle, the sum of the squared phase-voltage samples on six channels. The six channels are phases A, B and C, each in a raw and a filtered version. Every clock in which the sample-valid strobe is high, the block squares each channel's signed sample and aligns it into unsigned Q24.40. It then adds it to that channel's running sum. A separate counter tracks how many samples have arrived.

A single-clock cycle-end pulse closes the measurement period. In that clock the six running sums and the sample count are copied into read-only result registers, and the running sums restart from zero. The registers therefore always show the last completed cycle. Downstream logic divides a result by the count and takes a square root to get an RMS voltage. The number of samples per cycle is not fixed, so both the sums and the count saturate instead of wrapping.

Top module: `vsq_cycle_acc`

## Requirements
- R1: Channel k takes its sample from `smp_bus[k*SAMPLE_W +: SAMPLE_W]` and reports on `sum_bus[k*ACC_W +: ACC_W]`, with k = 0, 1, 2 for raw A, B, C and k = 3, 4, 5 for filtered A, B, C. Each result is the sum of the squares of that channel's valid samples in the finished cycle.
- R2: Samples are signed two's complement. Each square is shifted left by ALIGN_SH bits before it is added. A shifted square that does not fit in ACC_W bits is clamped to all ones.
- R3: After reset, every result, `n_last` and `res_rdy` are zero.
- R4: `sum_bus` and `n_last` change only on the clock edge that follows a cycle-end pulse, and hold their values at all other times.
- R5: A running sum saturates at the all-ones value of ACC_W bits and never wraps.
- R6: A sample that is valid in the same clock as the cycle-end pulse belongs to the cycle that is ending. The next cycle starts from zero.
- R7: `n_last` gives the number of valid samples in the finished cycle, and saturates at 2^CNT_W-1.
- R8: `res_rdy` is high for exactly the one clock after each cycle-end pulse and is low otherwise.
- R9: All six results and `n_last` update on the same clock edge.
- R10: A cycle with no valid samples reports zero on all six results and a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Samples on `smp_bus` are valid in this clock |
| cyc_end | input | 1 | Single-clock pulse that closes the line cycle |
| smp_bus | input | 6*SAMPLE_W | Six signed samples, one per channel, in the R1 order |
| sum_bus | output | 6*ACC_W | Six latched sums of squares, unsigned Q24.40 at default widths |
| n_last | output | CNT_W | Sample count of the last completed cycle |
| res_rdy | output | 1 | One-clock pulse when new results are latched |

## Verification
The bench uses a reduced configuration with 4-bit samples, 12-bit sums, a shift of 3 and a 4-bit count. It runs every ordered pair of sample values through two-sample cycles. Each channel gets a different offset, so every square is tested and a wrong channel mapping or a wrong sign treatment produces a different sum. Separate runs place a sample in the same clock as the cycle end, which checks that the sample lands in the closing cycle and that the next cycle restarts from zero. Further runs cover empty cycles and a 30-sample cycle in which some channels clip and others do not, which separates saturation from wrapping on both the sums and the count.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
    // Channel order on the sample and result buses.
    typedef enum logic [2:0] {
        CH_RAW_A  = 3'd0,
        CH_RAW_B  = 3'd1,
        CH_RAW_C  = 3'd2,
        CH_FILT_A = 3'd3,
        CH_FILT_B = 3'd4,
        CH_FILT_C = 3'd5
    } vsq_ch_e;

    localparam int NUM_CH = 6;
endpackage

// File: rtl/vsq_square_align.sv
// Squares one signed sample and aligns it into the accumulator format (R2).
module vsq_square_align #(
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 64,
    parameter int ALIGN_SH = 16
) (
    input  logic signed [SAMPLE_W-1:0] smp,
    output logic        [ACC_W-1:0]    term
);
    localparam int SQ_W   = 2 * SAMPLE_W;
    localparam int WIDE_W = SQ_W + ALIGN_SH;

    logic signed [SQ_W-1:0] ext;
    logic signed [SQ_W-1:0] sq;
    logic        [WIDE_W-1:0] wide;

    assign ext  = {{SAMPLE_W{smp[SAMPLE_W-1]}}, smp};
    assign sq   = ext * ext;
    assign wide = WIDE_W'(unsigned'(sq)) << ALIGN_SH;

    generate
        if (WIDE_W > ACC_W) begin : g_clip
            assign term = (|wide[WIDE_W-1:ACC_W]) ? {ACC_W{1'b1}} : wide[ACC_W-1:0];
        end else begin : g_fit
            assign term = ACC_W'(wide);
        end
    endgenerate
endmodule

// File: rtl/vsq_sat_accum.sv
// Saturating running sum with a synchronous restart. total is the value
// that includes the addend of the current clock (R5, R6).
module vsq_sat_accum #(
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             clr,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] total
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] raw_sum;

    always_comb begin
        raw_sum = {1'b0, st_q.acc} + {1'b0, addend};
        if (!add_en) begin
            total = st_q.acc;
        end else if (raw_sum[ACC_W]) begin
            total = {ACC_W{1'b1}};
        end else begin
            total = raw_sum[ACC_W-1:0];
        end
        st_d     = st_q;
        st_d.acc = clr ? '0 : total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: adding never makes the sum smaller.
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> (st_q.acc >= $past(st_q.acc)));

    // R5: once full, the sum stays full until restarted.
    a_r5_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.acc == {ACC_W{1'b1}}) && !clr) |=> (st_q.acc == {ACC_W{1'b1}}));

    // R6: a restart leaves zero behind.
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0));
endmodule

// File: rtl/vsq_cycle_acc.sv
module vsq_cycle_acc
    import vsq_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 64,
    parameter int ALIGN_SH = 16,
    parameter int CNT_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic                       cyc_end,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_bus,
    output logic [NUM_CH*ACC_W-1:0]    sum_bus,
    output logic [CNT_W-1:0]           n_last,
    output logic                       res_rdy
);
    typedef struct packed {
        logic [NUM_CH-1:0][ACC_W-1:0] res;
        logic [CNT_W-1:0]             n;
        logic                         rdy;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [NUM_CH-1:0][ACC_W-1:0] ch_term;
    logic [NUM_CH-1:0][ACC_W-1:0] ch_total;
    logic [CNT_W-1:0]             cnt_total;

    // R1, R2, R5: one square/align stage and one accumulator per channel.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic signed [SAMPLE_W-1:0] smp_k;
        assign smp_k = smp_bus[k*SAMPLE_W +: SAMPLE_W];

        vsq_square_align #(
            .SAMPLE_W (SAMPLE_W),
            .ACC_W    (ACC_W),
            .ALIGN_SH (ALIGN_SH)
        ) u_sq (
            .smp  (smp_k),
            .term (ch_term[k])
        );

        vsq_sat_accum #(
            .ACC_W (ACC_W)
        ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .add_en (smp_vld),
            .clr    (cyc_end),
            .addend (ch_term[k]),
            .total  (ch_total[k])
        );
    end

    // R7: sample counter, same saturating accumulator with a unit addend.
    vsq_sat_accum #(
        .ACC_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (smp_vld),
        .clr    (cyc_end),
        .addend (CNT_W'(1)),
        .total  (cnt_total)
    );

    // R4, R6, R8, R9: latch every result together on the cycle end.
    always_comb begin
        st_d     = st_q;
        st_d.rdy = cyc_end;
        if (cyc_end) begin
            for (int k = 0; k < NUM_CH; k++) begin
                st_d.res[k] = ch_total[k];
            end
            st_d.n = cnt_total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_bus = st_q.res;
    assign n_last  = st_q.n;
    assign res_rdy = st_q.rdy;

    // R8: the ready pulse follows a cycle end.
    a_r8_rdy_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> res_rdy);

    // R8: no ready pulse without a cycle end.
    a_r8_rdy_only_end: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> !res_rdy);

    // R4, R9: the results and the count hold between cycle ends.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> ($stable(sum_bus) && $stable(n_last)));
endmodule

// File: tb/tb_vsq_cycle_acc.sv
`timescale 1ns/1ps
module tb_vsq_cycle_acc;
    localparam int SW  = 4;
    localparam int AW  = 12;
    localparam int SH  = 3;
    localparam int CW  = 4;
    localparam int NCH = 6;
    localparam int AMAX = (1 << AW) - 1;
    localparam int CMAX = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic              cyc_end = 1'b0;
    logic [NCH*SW-1:0] smp_bus = '0;
    logic [NCH*AW-1:0] sum_bus;
    logic [CW-1:0]     n_last;
    logic              res_rdy;

    int n_cmp = 0;
    int n_bad = 0;
    int m_acc [NCH];
    int m_n = 0;
    int e_res [NCH];
    int e_n = 0;

    always #4 clk = ~clk;

    vsq_cycle_acc #(
        .SAMPLE_W (SW),
        .ACC_W    (AW),
        .ALIGN_SH (SH),
        .CNT_W    (CW)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .cyc_end (cyc_end),
        .smp_bus (smp_bus),
        .sum_bus (sum_bus),
        .n_last  (n_last),
        .res_rdy (res_rdy)
    );

    function automatic int wrapv(input int x);
        return (((x + 8) % 16) + 16) % 16 - 8;
    endfunction

    function automatic int sq_term(input int v);
        int t;
        t = v * v * (1 << SH);
        return (t > AMAX) ? AMAX : t;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input bit exp_rdy, input string req);
        for (int k = 0; k < NCH; k++) begin
            int got;
            got = int'(sum_bus[k*AW +: AW]);
            chk(got == e_res[k], req, got, e_res[k]);
        end
        chk(int'(n_last) == e_n, req, int'(n_last), e_n);
        chk(res_rdy == exp_rdy, "R8", int'(res_rdy), int'(exp_rdy));
    endtask

    // Channel k gets wrapv(base + 3*k).
    task automatic step(input bit vld, input bit ce, input int base, input string req);
        @(negedge clk);
        smp_vld = vld;
        cyc_end = ce;
        for (int k = 0; k < NCH; k++) begin
            smp_bus[k*SW +: SW] = SW'(wrapv(base + 3 * k));
        end
        if (vld) begin
            for (int k = 0; k < NCH; k++) begin
                m_acc[k] = m_acc[k] + sq_term(wrapv(base + 3 * k));
                if (m_acc[k] > AMAX) m_acc[k] = AMAX;
            end
            if (m_n < CMAX) m_n++;
        end
        if (ce) begin
            for (int k = 0; k < NCH; k++) begin
                e_res[k] = m_acc[k];
                m_acc[k] = 0;
            end
            e_n = m_n;
            m_n = 0;
        end
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
        cyc_end = 1'b0;
        @(negedge clk);
        check_all(ce, req);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NCH; k++) begin
            m_acc[k] = 0;
            e_res[k] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R3: reset state
        @(negedge clk);
        check_all(1'b0, "R3");
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1'b0, "R3");

        // R1, R2, R4, R9: every ordered pair of sample values
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1'b1, 1'b0, a - 8, "R4");
                step(1'b1, 1'b0, b - 8, "R4");
                step(1'b0, 1'b1, 0, "R1/R2/R9");
            end
        end

        // R6: sample coincident with cycle end, then fresh cycle
        for (int a = 0; a < 16; a++) begin
            step(1'b1, 1'b0, a - 8, "R4");
            step(1'b1, 1'b1, 7 - a, "R6");
            step(1'b1, 1'b0, a - 3, "R4");
            step(1'b0, 1'b1, 0, "R6");
        end

        // R10: empty cycles
        step(1'b0, 1'b1, 0, "R10");
        step(1'b0, 1'b1, 0, "R10");

        // R5, R7: long cycle, some channels clip, count clips
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 1'b0, -8, "R4");
        end
        step(1'b0, 1'b1, 0, "R5/R7");
        // restart after saturation
        step(1'b1, 1'b0, 2, "R4");
        step(1'b0, 1'b1, 0, "R6");

        // R7: count exactly at the limit
        for (int i = 0; i < CMAX; i++) begin
            step(1'b1, 1'b0, i, "R4");
        end
        step(1'b0, 1'b1, 0, "R7");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule